// File: doc/BRIEF.md
# Processor Mode Summary Register

This block keeps a registered digest of the processor's execution state, so that instruction decode does not have to rebuild it every cycle. It records the top-level mode (legacy or long), a finer submode (real, virtual-8086, protected, compatibility or 64-bit), the current privilege level, the paging and protection enables, the default and alternate operand sizes, the default and alternate address sizes, and the stack width. Size fields use code 1 for 16-bit, 2 for 32-bit and 3 for 64-bit.

The digest changes only on an update event. An update event is a write to the control register that holds the protection and paging enables, a write to the code-segment attributes, a write to the stack-segment attributes, a write aimed at the digest itself (a refresh), or a state-restore request. The write ports carry the new field values. In the cycle of a write, those values take the place of the matching current-state inputs. A refresh or a restore recomputes the digest from the current-state inputs alone. The register loads on the clock edge that samples the event. Reset is asynchronous and active low, and its release is synchronised inside the block.

Top module: `mode_summary_reg`

## Requirements
- R1: After reset every output is zero: mode 0 (legacy), submode 0 (real), privilege 0, flags 0 and every size code 0.
- R2: With long-mode-active set, mode is 1 (long). Submode is 4 (64-bit) when the code-segment long bit is set and 3 (compatibility) when it is clear. The virtual-8086 flag has no effect in this mode.
- R3: With long-mode-active clear, mode is 0 (legacy). Submode is 0 (real) when the protection enable is clear, 1 (virtual-8086) when protection and the virtual-8086 flag are both set, and 2 (protected) otherwise.
- R4: The privilege output equals the code-segment privilege field. The paging output equals the paging enable, and the protection output equals the protection enable.
- R5: Operand size is default 2, alternate 1 in submode 4 or when the code-segment default-size bit is set. Otherwise it is default 1, alternate 2.
- R6: Address size is default 3, alternate 2 in submode 4. Otherwise it is default 2, alternate 1 when the code-segment default-size bit is set, and default 1, alternate 2 when that bit is clear.
- R7: Stack size is 3 in submode 4. Otherwise it is 2 when the stack-segment default-size bit is set, and 1 when it is clear.
- R8: A control-register write uses the written protection and paging values, not the current-state inputs.
- R9: A code-segment attribute write uses the written long bit, default-size bit and privilege, not the current-state inputs.
- R10: A stack-segment attribute write uses the written default-size bit, not the current-state input.
- R11: A refresh request recomputes the digest from the current-state inputs.
- R12: A restore request recomputes the digest from the current-state inputs.
- R13: When no update event occurs, all outputs hold their values, even while the current-state inputs change. The new value of an update appears after the clock edge that samples the event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cur_lma | input | 1 | Long mode active flag |
| cur_pe | input | 1 | Current protection enable |
| cur_pg | input | 1 | Current paging enable |
| cur_vm | input | 1 | Virtual-8086 flag |
| cur_cs_long | input | 1 | Current code-segment long bit |
| cur_cs_dsize | input | 1 | Current code-segment default-size bit |
| cur_cs_dpl | input | 2 | Current code-segment privilege level |
| cur_ss_dsize | input | 1 | Current stack-segment default-size bit |
| wr_ctl | input | 1 | Control-register write strobe |
| wr_ctl_pe | input | 1 | Written protection enable |
| wr_ctl_pg | input | 1 | Written paging enable |
| wr_cs | input | 1 | Code-segment attribute write strobe |
| wr_cs_long | input | 1 | Written code-segment long bit |
| wr_cs_dsize | input | 1 | Written code-segment default-size bit |
| wr_cs_dpl | input | 2 | Written code-segment privilege level |
| wr_ss | input | 1 | Stack-segment attribute write strobe |
| wr_ss_dsize | input | 1 | Written stack-segment default-size bit |
| refresh_req | input | 1 | Write aimed at the digest, recompute from current state |
| restore_req | input | 1 | State-restore recompute request |
| mode_o | output | 1 | 0 legacy, 1 long |
| submode_o | output | 3 | 0 real, 1 v86, 2 protected, 3 compat, 4 64-bit |
| cpl_o | output | 2 | Current privilege level |
| paging_o | output | 1 | Paging enabled |
| prot_o | output | 1 | Protection enabled |
| op_def_o | output | 2 | Default operand size code |
| op_alt_o | output | 2 | Alternate operand size code |
| addr_def_o | output | 2 | Default address size code |
| addr_alt_o | output | 2 | Alternate address size code |
| stack_o | output | 2 | Stack size code |

## Verification
The stimulus walks through every submode: real, protected and virtual-8086 with long mode off, then compatibility and 64-bit with long mode on. The 64-bit case sets the virtual-8086 flag, which shows that the flag is ignored in long mode. Each write strobe is driven with write data that differs from the current-state inputs. A digest that follows the wrong source is therefore seen at once, and refresh and restore are shown to read the current state. Cycles with no event are driven while the current-state inputs toggle, which separates a held digest from one that follows its inputs. The default-size bits of the code and stack segments are varied apart from each other, so that operand, address and stack sizes are checked against the correct source bit.

// File: rtl/msr_pkg.sv
package msr_pkg;
  localparam int DPL_W  = 2;
  localparam int SIZE_W = 2;
  localparam int SUB_W  = 3;

  typedef enum logic {
    MODE_LEGACY = 1'b0,
    MODE_LONG   = 1'b1
  } mode_e;

  typedef enum logic [SUB_W-1:0] {
    SUB_REAL   = 3'd0,
    SUB_V86    = 3'd1,
    SUB_PROT   = 3'd2,
    SUB_COMPAT = 3'd3,
    SUB_64     = 3'd4
  } submode_e;

  localparam logic [SIZE_W-1:0] SZ_16 = 2'd1;
  localparam logic [SIZE_W-1:0] SZ_32 = 2'd2;
  localparam logic [SIZE_W-1:0] SZ_64 = 2'd3;

  typedef struct packed {
    logic pe;
    logic pg;
  } ctl_bits_t;

  typedef struct packed {
    logic             long_b;
    logic             dsize;
    logic [DPL_W-1:0] dpl;
  } cs_attr_t;

  typedef struct packed {
    logic [SIZE_W-1:0] op_def;
    logic [SIZE_W-1:0] op_alt;
    logic [SIZE_W-1:0] addr_def;
    logic [SIZE_W-1:0] addr_alt;
    logic [SIZE_W-1:0] stack;
  } sizes_t;

  typedef struct packed {
    mode_e            mode;
    submode_e         sub;
    logic [DPL_W-1:0] cpl;
    logic             paging;
    logic             prot;
    sizes_t           sz;
  } summary_t;
endpackage

// File: rtl/msr_rst_sync.sv
module msr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/msr_src_select.sv
module msr_src_select
  import msr_pkg::*;
(
  input  ctl_bits_t cur_ctl,
  input  cs_attr_t  cur_cs,
  input  logic      cur_ss_dsize,
  input  logic      wr_ctl,
  input  ctl_bits_t wr_ctl_val,
  input  logic      wr_cs,
  input  cs_attr_t  wr_cs_val,
  input  logic      wr_ss,
  input  logic      wr_ss_dsize,
  input  logic      refresh_req,
  input  logic      restore_req,
  output ctl_bits_t sel_ctl,
  output cs_attr_t  sel_cs,
  output logic      sel_ss_dsize,
  output logic      update
);
  // A write in flight replaces the stored value it targets.
  always_comb begin
    sel_ctl      = wr_ctl ? wr_ctl_val  : cur_ctl;
    sel_cs       = wr_cs  ? wr_cs_val   : cur_cs;
    sel_ss_dsize = wr_ss  ? wr_ss_dsize : cur_ss_dsize;
    update       = wr_ctl | wr_cs | wr_ss | refresh_req | restore_req;
  end
endmodule

// File: rtl/msr_mode_decode.sv
module msr_mode_decode
  import msr_pkg::*;
(
  input  logic      lma,
  input  logic      vm,
  input  ctl_bits_t ctl,
  input  logic      cs_long,
  output mode_e     mode,
  output submode_e  sub
);
  always_comb begin
    if (lma) begin
      mode = MODE_LONG;
      sub  = cs_long ? SUB_64 : SUB_COMPAT;
    end else begin
      mode = MODE_LEGACY;
      if (!ctl.pe)  sub = SUB_REAL;
      else if (vm)  sub = SUB_V86;
      else          sub = SUB_PROT;
    end
  end
endmodule

// File: rtl/msr_size_decode.sv
module msr_size_decode
  import msr_pkg::*;
(
  input  submode_e sub,
  input  logic     cs_dsize,
  input  logic     ss_dsize,
  output sizes_t   sz
);
  logic is64;

  always_comb begin
    is64 = (sub == SUB_64);

    if (is64 || cs_dsize) begin
      sz.op_def = SZ_32;
      sz.op_alt = SZ_16;
    end else begin
      sz.op_def = SZ_16;
      sz.op_alt = SZ_32;
    end

    if (is64) begin
      sz.addr_def = SZ_64;
      sz.addr_alt = SZ_32;
    end else if (cs_dsize) begin
      sz.addr_def = SZ_32;
      sz.addr_alt = SZ_16;
    end else begin
      sz.addr_def = SZ_16;
      sz.addr_alt = SZ_32;
    end

    if (is64)          sz.stack = SZ_64;
    else if (ss_dsize) sz.stack = SZ_32;
    else               sz.stack = SZ_16;
  end
endmodule

// File: rtl/mode_summary_reg.sv
module mode_summary_reg
  import msr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cur_lma,
  input  logic       cur_pe,
  input  logic       cur_pg,
  input  logic       cur_vm,
  input  logic       cur_cs_long,
  input  logic       cur_cs_dsize,
  input  logic [1:0] cur_cs_dpl,
  input  logic       cur_ss_dsize,
  input  logic       wr_ctl,
  input  logic       wr_ctl_pe,
  input  logic       wr_ctl_pg,
  input  logic       wr_cs,
  input  logic       wr_cs_long,
  input  logic       wr_cs_dsize,
  input  logic [1:0] wr_cs_dpl,
  input  logic       wr_ss,
  input  logic       wr_ss_dsize,
  input  logic       refresh_req,
  input  logic       restore_req,
  output logic       mode_o,
  output logic [2:0] submode_o,
  output logic [1:0] cpl_o,
  output logic       paging_o,
  output logic       prot_o,
  output logic [1:0] op_def_o,
  output logic [1:0] op_alt_o,
  output logic [1:0] addr_def_o,
  output logic [1:0] addr_alt_o,
  output logic [1:0] stack_o
);
  logic      rst_sync_n;
  ctl_bits_t sel_ctl;
  cs_attr_t  sel_cs;
  logic      sel_ss_dsize;
  logic      update;
  mode_e     nx_mode;
  submode_e  nx_sub;
  sizes_t    nx_sz;
  summary_t  sum_d, sum_q;

  msr_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  msr_src_select u_sel (
    .cur_ctl     ('{pe: cur_pe, pg: cur_pg}),
    .cur_cs      ('{long_b: cur_cs_long, dsize: cur_cs_dsize, dpl: cur_cs_dpl}),
    .cur_ss_dsize(cur_ss_dsize),
    .wr_ctl      (wr_ctl),
    .wr_ctl_val  ('{pe: wr_ctl_pe, pg: wr_ctl_pg}),
    .wr_cs       (wr_cs),
    .wr_cs_val   ('{long_b: wr_cs_long, dsize: wr_cs_dsize, dpl: wr_cs_dpl}),
    .wr_ss       (wr_ss),
    .wr_ss_dsize (wr_ss_dsize),
    .refresh_req (refresh_req),
    .restore_req (restore_req),
    .sel_ctl     (sel_ctl),
    .sel_cs      (sel_cs),
    .sel_ss_dsize(sel_ss_dsize),
    .update      (update)
  );

  msr_mode_decode u_mode (
    .lma(cur_lma), .vm(cur_vm), .ctl(sel_ctl), .cs_long(sel_cs.long_b),
    .mode(nx_mode), .sub(nx_sub)
  );

  msr_size_decode u_size (
    .sub(nx_sub), .cs_dsize(sel_cs.dsize), .ss_dsize(sel_ss_dsize), .sz(nx_sz)
  );

  // Next-state assembly
  always_comb begin
    sum_d.mode   = nx_mode;
    sum_d.sub    = nx_sub;
    sum_d.cpl    = sel_cs.dpl;
    sum_d.paging = sel_ctl.pg;
    sum_d.prot   = sel_ctl.pe;
    sum_d.sz     = nx_sz;
  end

  // Summary register, loaded only on an update event
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  sum_q <= '0;
    else if (update)  sum_q <= sum_d;
  end

  assign mode_o     = sum_q.mode;
  assign submode_o  = sum_q.sub;
  assign cpl_o      = sum_q.cpl;
  assign paging_o   = sum_q.paging;
  assign prot_o     = sum_q.prot;
  assign op_def_o   = sum_q.sz.op_def;
  assign op_alt_o   = sum_q.sz.op_alt;
  assign addr_def_o = sum_q.sz.addr_def;
  assign addr_alt_o = sum_q.sz.addr_alt;
  assign stack_o    = sum_q.sz.stack;

  a_r13_hold_without_event: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !$past(update) |-> $stable(sum_q));

  a_r2_sub64_is_long: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (sum_q.sub == SUB_64) |-> (sum_q.mode == MODE_LONG));

  a_r3_unprotected_is_real: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (sum_q.mode == MODE_LEGACY && !sum_q.prot) |-> (sum_q.sub == SUB_REAL));

  a_r5_sub64_operand: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (sum_q.sub == SUB_64) |-> (sum_q.sz.op_def == SZ_32 && sum_q.sz.op_alt == SZ_16));

  a_r7_sub64_stack: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (sum_q.sub == SUB_64) |-> (sum_q.sz.stack == SZ_64));

  a_r4_cpl_follows_cs: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $past(update) |-> (sum_q.cpl == $past(sel_cs.dpl)));
endmodule

// File: tb/test_mode_summary_reg.sv
module test_mode_summary_reg;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic       cur_lma = 0, cur_pe = 0, cur_pg = 0, cur_vm = 0;
  logic       cur_cs_long = 0, cur_cs_dsize = 0, cur_ss_dsize = 0;
  logic [1:0] cur_cs_dpl = 0;
  logic       wr_ctl = 0, wr_ctl_pe = 0, wr_ctl_pg = 0;
  logic       wr_cs = 0, wr_cs_long = 0, wr_cs_dsize = 0;
  logic [1:0] wr_cs_dpl = 0;
  logic       wr_ss = 0, wr_ss_dsize = 0;
  logic       refresh_req = 0, restore_req = 0;
  logic       mode_o, paging_o, prot_o;
  logic [2:0] submode_o;
  logic [1:0] cpl_o, op_def_o, op_alt_o, addr_def_o, addr_alt_o, stack_o;

  mode_summary_reg i_mode_summary_reg (.*);

  int checks = 0;
  int fails  = 0;
  logic [17:0] model = '0;
  logic [17:0] exp_q[$];
  string       tag_q[$];

  function automatic logic [17:0] calc(logic lma, logic pe, logic pg, logic vm,
                                       logic cl, logic cd, logic [1:0] dpl, logic sd);
    logic [2:0] sub;
    logic       is64;
    logic [1:0] od, oa, ad, aa, st;
    is64 = lma && cl;
    if (lma)      sub = cl ? 3'd4 : 3'd3;
    else if (!pe) sub = 3'd0;
    else if (vm)  sub = 3'd1;
    else          sub = 3'd2;
    if (is64 || cd) begin od = 2; oa = 1; end else begin od = 1; oa = 2; end
    if (is64)       begin ad = 3; aa = 2; end
    else if (cd)    begin ad = 2; aa = 1; end
    else            begin ad = 1; aa = 2; end
    st = is64 ? 2'd3 : (sd ? 2'd2 : 2'd1);
    return {lma, sub, dpl, pg, pe, od, oa, ad, aa, st};
  endfunction

  function automatic logic [17:0] outs();
    return {mode_o, submode_o, cpl_o, paging_o, prot_o,
            op_def_o, op_alt_o, addr_def_o, addr_alt_o, stack_o};
  endfunction

  // Driver: one cycle per call, pushes the expected digest
  task automatic cycle(input logic c, input logic s, input logic t,
                       input logic rf, input logic rs, input string tag);
    @(negedge clk);
    wr_ctl = c; wr_cs = s; wr_ss = t; refresh_req = rf; restore_req = rs;
    if (c | s | t | rf | rs)
      model = calc(cur_lma, c ? wr_ctl_pe : cur_pe, c ? wr_ctl_pg : cur_pg, cur_vm,
                   s ? wr_cs_long : cur_cs_long, s ? wr_cs_dsize : cur_cs_dsize,
                   s ? wr_cs_dpl : cur_cs_dpl, t ? wr_ss_dsize : cur_ss_dsize);
    exp_q.push_back(model);
    tag_q.push_back(tag);
    @(posedge clk);
    #1;
    wr_ctl = 0; wr_cs = 0; wr_ss = 0; refresh_req = 0; restore_req = 0;
  endtask

  // Monitor
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        logic [17:0] e;
        string       tg;
        e  = exp_q.pop_front();
        tg = tag_q.pop_front();
        checks++;
        if (outs() !== e) begin
          fails++;
          $display("FAIL %s: actual %h expected %h", tg, outs(), e);
        end
      end
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #100000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #2;
    checks++;
    if (outs() !== 18'h0) begin
      fails++;
      $display("FAIL R1: actual %h expected %h", outs(), 18'h0);
    end

    // R11 R3: refresh in real mode, current state
    cur_cs_dpl = 2'd0;
    cycle(0, 0, 0, 1, 0, "R11 R3 real");
    // R13: inputs change, no event
    cur_pe = 1; cur_cs_dsize = 1; cur_ss_dsize = 1; cur_lma = 1;
    cycle(0, 0, 0, 0, 0, "R13 hold");
    cycle(0, 0, 0, 0, 0, "R13 hold again");
    cur_lma = 0; cur_pe = 0; cur_cs_dsize = 0; cur_ss_dsize = 0;
    // R8 R3: control write protection on, paging on, current says off
    wr_ctl_pe = 1; wr_ctl_pg = 1;
    cycle(1, 0, 0, 0, 0, "R8 R3 R4 protected");
    // R3: virtual-8086 via refresh
    cur_pe = 1; cur_vm = 1;
    cycle(0, 0, 0, 1, 0, "R3 R11 v86");
    cur_vm = 0;
    // R9 R5 R6 R4: code-segment write default size, privilege 3
    wr_cs_long = 0; wr_cs_dsize = 1; wr_cs_dpl = 2'd3;
    cycle(0, 1, 0, 0, 0, "R9 R5 R6 R4 cs write");
    // R10 R7: stack write sets 32-bit stack, current says 16
    wr_ss_dsize = 1;
    cycle(0, 0, 1, 0, 0, "R10 R7 ss write");
    // R13 after update
    cur_cs_dpl = 2'd1;
    cycle(0, 0, 0, 0, 0, "R13 hold after write");
    // R2: 64-bit, vm set must be ignored
    cur_lma = 1; cur_cs_long = 1; cur_vm = 1; cur_cs_dsize = 0; cur_ss_dsize = 0;
    cycle(0, 0, 0, 1, 0, "R2 R5 R6 R7 64-bit");
    cur_vm = 0;
    // R12 R2: restore into compatibility, 16-bit sizes
    cur_cs_long = 0; cur_cs_dpl = 2'd2; cur_pg = 1;
    cycle(0, 0, 0, 0, 1, "R12 R2 compat");
    // R6: compatibility with 32-bit code, 16-bit stack
    wr_cs_long = 0; wr_cs_dsize = 1; wr_cs_dpl = 2'd0;
    cycle(0, 1, 0, 0, 0, "R6 R9 compat32");
    // R9: code write turning on 64-bit while current says compat
    wr_cs_long = 1; wr_cs_dsize = 0;
    cycle(0, 1, 0, 0, 0, "R9 R2 64 via write");
    // R8: control write with paging off while current says on
    wr_ctl_pe = 1; wr_ctl_pg = 0;
    cycle(1, 0, 0, 0, 0, "R8 R4 paging off");
    // R3: legacy, protection cleared by write
    cur_lma = 0; cur_cs_long = 0; wr_ctl_pe = 0; wr_ctl_pg = 0;
    cycle(1, 0, 0, 0, 0, "R8 R3 real via write");
    // R10: stack write clears default size while current says set
    cur_ss_dsize = 1; wr_ss_dsize = 0;
    cycle(0, 0, 1, 0, 0, "R10 R7 stack 16");
    repeat (3) @(posedge clk);
    #3;
    finish_run();
  end
endmodule